// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives the ORed product terms of its slice of the AND array as a single sum term. Two configuration bits decide how that sum reaches the pin. One bit chooses between a clocked path, where an edge-triggered flip-flop sits in front of the pin, and a transparent combinational path. The other bit chooses whether the pin is active-high or active-low. A separate product term gates the pin driver. A feedback line goes back into the AND array. It carries the flip-flop state in clocked mode and the pin value in combinational mode, so a combinational cell can also serve as an input or as a bidirectional pin.

The asynchronous set and clear terms are shared by every cell of a device. They act on the flip-flop before the polarity stage. The same set pulse therefore drives an active-high pin high and an active-low pin low. A power-up reset clears the flip-flop at once and is released only after two clock edges. A preload path writes any chosen value into the flip-flop on a clock edge, so a state machine built from several cells can be started in any state. The bidirectional pin is modelled as three separate signals: drive value, drive enable and pin input.

Top module: `pal_mcell`

## Requirements
- R1: With `cfg_reg_i`=1, the flip-flop takes `sum_i` on each rising edge of `clk_i`, and the pin data comes from the flip-flop, not from `sum_i`.
- R2: With `cfg_reg_i`=0, the pin data follows `sum_i` in the same cycle, with no clock edge needed.
- R3: With `cfg_pol_i`=1 the pin drives the data unchanged (active-high). With `cfg_pol_i`=0 it drives the inverted data (active-low). This applies in both modes.
- R4: A high `areset_i` clears the flip-flop to 0 at once, with no clock edge, and holds it at 0 while the signal stays high, whatever clock edges arrive.
- R5: A high `apreset_i` sets the flip-flop to 1 at once, with no clock edge. In clocked mode the pin then reads 1 when `cfg_pol_i`=1 and 0 when `cfg_pol_i`=0.
- R6: When `areset_i` and `apreset_i` are both high, the flip-flop is 0.
- R7: `pin_oe_o` follows `oe_term_i`. A low term leaves the pin undriven, and a held high term makes it a permanent output.
- R8: `fb_o` equals the flip-flop state when `cfg_reg_i`=1 and equals `pin_i` when `cfg_reg_i`=0.
- R9: A low `rst_ni` clears the flip-flop at once. After `rst_ni` rises, the flip-flop stays 0 through the first two rising clock edges and loads normally from the third.
- R10: A high `preload_en_i` at a rising edge loads `preload_val_i` into the flip-flop instead of `sum_i`. This happens whatever the mode and polarity.
- R11: Priority runs as follows: the asynchronous clear and set come before preload, and preload comes before the normal sum capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Power-up reset, active low, asserted asynchronously and released after two edges |
| cfg_reg_i | input | 1 | 1 = clocked mode, 0 = combinational mode |
| cfg_pol_i | input | 1 | 1 = active-high pin, 0 = active-low pin |
| sum_i | input | 1 | OR of the cell's product terms |
| oe_term_i | input | 1 | Output-enable product term |
| apreset_i | input | 1 | Global asynchronous set term |
| areset_i | input | 1 | Global asynchronous clear term |
| preload_en_i | input | 1 | Preload strobe, sampled on the clock edge |
| preload_val_i | input | 1 | Value to preload |
| pin_i | input | 1 | Value seen on the pin |
| pin_drive_o | output | 1 | Value driven onto the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback to the AND array |

## Verification
The bench raises the clear and set terms between clock edges and checks the pin before the next edge. A design that waited for the clock, or inverted the set before the polarity stage, would show a wrong pin level there. It asserts both terms together and preload together with clear, to catch a reversed priority. It also checks that two edges pass after power-up release with the flip-flop still clear, which a design without the release delay would miss. In combinational mode it drives `pin_i` apart from `sum_i`, so a design that fed back the wrong source shows a mismatch on `fb_o`.

// File: rtl/pal_mcell_pkg.sv
package pal_mcell_pkg;

  typedef struct packed {
    logic registered;
    logic act_high;
  } mcell_cfg_t;

  localparam int unsigned RST_SYNC_STAGES = 2;

  function automatic logic apply_pol(input logic d, input logic act_high);
    return act_high ? d : ~d;
  endfunction

endpackage

// File: rtl/mcell_rst_sync.sv
module mcell_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/mcell_flop.sv
module mcell_flop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic areset_i,
  input  logic apreset_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  input  logic d_i,
  output logic q_o
);
  // clear beats set; both beat preload; preload beats d
  always_ff @(posedge clk_i or negedge rst_ni or posedge areset_i or posedge apreset_i) begin
    if (!rst_ni || areset_i) q_o <= 1'b0;
    else if (apreset_i)      q_o <= 1'b1;
    else if (preload_en_i)   q_o <= preload_val_i;
    else                     q_o <= d_i;
  end
endmodule

// File: rtl/mcell_out_sel.sv
module mcell_out_sel
  import pal_mcell_pkg::*;
(
  input  mcell_cfg_t cfg_i,
  input  logic       sum_i,
  input  logic       q_i,
  input  logic       pin_i,
  output logic       drive_o,
  output logic       fb_o
);
  logic data;

  always_comb begin
    data    = cfg_i.registered ? q_i : sum_i;
    drive_o = apply_pol(data, cfg_i.act_high);
    fb_o    = cfg_i.registered ? q_i : pin_i;
  end
endmodule

// File: rtl/pal_mcell.sv
module pal_mcell
  import pal_mcell_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_reg_i,
  input  logic cfg_pol_i,
  input  logic sum_i,
  input  logic oe_term_i,
  input  logic apreset_i,
  input  logic areset_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  input  logic pin_i,
  output logic pin_drive_o,
  output logic pin_oe_o,
  output logic fb_o
);
  mcell_cfg_t cfg;
  logic       core_rst_n;
  logic       reg_q;

  assign cfg.registered = cfg_reg_i;
  assign cfg.act_high   = cfg_pol_i;

  mcell_rst_sync #(.STAGES(RST_SYNC_STAGES)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (core_rst_n)
  );

  mcell_flop i_flop (
    .clk_i         (clk_i),
    .rst_ni        (core_rst_n),
    .areset_i      (areset_i),
    .apreset_i     (apreset_i),
    .preload_en_i  (preload_en_i),
    .preload_val_i (preload_val_i),
    .d_i           (sum_i),
    .q_o           (reg_q)
  );

  mcell_out_sel i_out_sel (
    .cfg_i   (cfg),
    .sum_i   (sum_i),
    .q_i     (reg_q),
    .pin_i   (pin_i),
    .drive_o (pin_drive_o),
    .fb_o    (fb_o)
  );

  assign pin_oe_o = oe_term_i;
endmodule

// File: rtl/pal_mcell_chk.sv
module pal_mcell_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_reg_i,
  input logic cfg_pol_i,
  input logic sum_i,
  input logic apreset_i,
  input logic areset_i,
  input logic preload_en_i,
  input logic preload_val_i,
  input logic pin_i,
  input logic pin_drive_o,
  input logic fb_o,
  input logic reg_q,
  input logic core_rst_n
);
  logic quiet;
  assign quiet = core_rst_n && !areset_i && !apreset_i;

  AST_CLEAR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    areset_i |-> !reg_q); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (areset_i && apreset_i) |=> (!reg_q || !areset_i)); // R6

  AST_SET_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apreset_i && !areset_i && core_rst_n) |=> (reg_q || areset_i || !core_rst_n)); // R5

  AST_PRELOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && preload_en_i) |=> (reg_q == $past(preload_val_i) || areset_i || apreset_i)); // R10

  AST_SUM_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !preload_en_i) |=> (reg_q == $past(sum_i) || areset_i || apreset_i)); // R1

  AST_FB_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reg_i |-> fb_o == reg_q); // R8

  AST_FB_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_reg_i |-> fb_o == pin_i); // R8

  AST_POL_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reg_i |-> pin_drive_o == (cfg_pol_i ? reg_q : !reg_q)); // R3

  AST_POWERUP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_n |-> !reg_q); // R9
endmodule

bind pal_mcell pal_mcell_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_reg_i     (cfg_reg_i),
  .cfg_pol_i     (cfg_pol_i),
  .sum_i         (sum_i),
  .apreset_i     (apreset_i),
  .areset_i      (areset_i),
  .preload_en_i  (preload_en_i),
  .preload_val_i (preload_val_i),
  .pin_i         (pin_i),
  .pin_drive_o   (pin_drive_o),
  .fb_o          (fb_o),
  .reg_q         (reg_q),
  .core_rst_n    (core_rst_n)
);

// File: tb/test_pal_mcell.sv
module test_pal_mcell;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_reg = 1'b1, cfg_pol = 1'b1, sum = 1'b0, oe = 1'b0;
  logic ap = 1'b0, ar = 1'b0, pe = 1'b0, pv = 1'b0, pin = 1'b0;
  logic drv, oe_o, fb;

  int checks = 0;
  int errors = 0;
  int rel_edges = 0;
  bit m_q = 1'b0;

  always #5 clk = ~clk;

  pal_mcell i_pal_mcell (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_reg_i(cfg_reg), .cfg_pol_i(cfg_pol),
    .sum_i(sum), .oe_term_i(oe), .apreset_i(ap), .areset_i(ar),
    .preload_en_i(pe), .preload_val_i(pv), .pin_i(pin),
    .pin_drive_o(drv), .pin_oe_o(oe_o), .fb_o(fb)
  );

  task automatic check(input string tag);
    bit d, e_drv, e_fb;
    d     = cfg_reg ? m_q : sum;
    e_drv = cfg_pol ? d : !d;
    e_fb  = cfg_reg ? m_q : pin;
    checks++;
    if ({drv, oe_o, fb} !== {e_drv, oe, e_fb}) begin
      errors++;
      $display("FAIL %s drv/oe/fb act=%b%b%b exp=%b%b%b", tag, drv, oe_o, fb, e_drv, oe, e_fb);
    end
  endtask

  // drive at negedge, check mid-cycle and after the next rising edge
  task automatic cyc(input string tag, input logic rn, input logic rg, input logic pl,
                     input logic s, input logic o, input logic a_p, input logic a_r,
                     input logic p_e, input logic p_v, input logic pn);
    @(negedge clk);
    rst_ni = rn; cfg_reg = rg; cfg_pol = pl; sum = s; oe = o;
    ap = a_p; ar = a_r; pe = p_e; pv = p_v; pin = pn;
    if (!rn) rel_edges = 0;
    #1;
    if (!rn || a_r) m_q = 1'b0;
    else if (a_p && rel_edges >= 2) m_q = 1'b1;
    check(tag);
    @(posedge clk);
    if (!rn || rel_edges < 2 || a_r) m_q = 1'b0;
    else if (a_p) m_q = 1'b1;
    else if (p_e) m_q = p_v;
    else m_q = s;
    if (rn && rel_edges < 2) rel_edges++;
    #1;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    //              tag       rn rg pl s  oe ap ar pe pv pin
    cyc("R9 reset",   0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R9 reset",   0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R9 release", 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R9 release", 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R1 capture", 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R1 capture", 1, 1, 1, 0, 1, 0, 0, 0, 0, 1);
    cyc("R1 capture", 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R3 act-low", 1, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    cyc("R3 act-low", 1, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    cyc("R2 comb",    1, 0, 1, 0, 1, 0, 0, 0, 0, 1);
    cyc("R2 comb",    1, 0, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R3 comb-low",1, 0, 0, 1, 1, 0, 0, 0, 0, 1);
    cyc("R8 fb pin",  1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R8 fb pin",  1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R7 oe off",  1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
    cyc("R7 oe on",   1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R4 clear",   1, 1, 1, 1, 1, 0, 1, 0, 0, 0);
    cyc("R4 clear",   1, 1, 1, 1, 1, 0, 1, 0, 0, 0);
    cyc("R4 release", 1, 1, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc("R5 set hi",  1, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    cyc("R5 set hi",  1, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    cyc("R5 set low", 1, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    cyc("R6 both",    1, 1, 1, 1, 1, 1, 1, 0, 0, 0);
    cyc("R6 both",    1, 1, 0, 1, 1, 1, 1, 1, 1, 0);
    cyc("R6 drop",    1, 1, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc("R10 preload",1, 1, 1, 0, 1, 0, 0, 1, 1, 0);
    cyc("R10 preload",1, 1, 1, 1, 1, 0, 0, 1, 0, 0);
    cyc("R10 comb",   1, 0, 0, 0, 1, 0, 0, 1, 1, 1);
    cyc("R10 back",   1, 1, 1, 0, 1, 0, 0, 1, 1, 0);
    cyc("R11 clr>pl", 1, 1, 1, 1, 1, 0, 1, 1, 1, 0);
    cyc("R11 pl>sum", 1, 1, 1, 1, 1, 0, 0, 1, 0, 0);
    cyc("R11 set>pl", 1, 1, 1, 0, 1, 1, 0, 1, 0, 0);
    cyc("R11 sum",    1, 1, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc("R9 rearm",   1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R9 rearm",   0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R9 release", 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R9 release", 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R1 resume",  1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    cyc("R1 resume",  1, 1, 1, 0, 1, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule